// File: doc/BRIEF.md
# Seven-to-one pixel lane serializer

This block turns a parallel video pixel (8-bit red, green and blue, plus horizontal sync, vertical sync and data-enable) into four serial data lanes and one serial clock lane for a flat-panel link. Every pixel period is cut into seven single-data-rate bit slots. One fast clock runs at seven times the pixel rate and drives everything. All shifting is done in ordinary flip-flops, with no dedicated serializer cells.

A modulo-7 phase counter marks slot boundaries. On the phase-0 cycle, all five 7-bit shift registers load in parallel, and a one-cycle strobe is raised. An upstream producer on the same fast clock holds the pixel stable while the strobe is high. It may change the pixel on the clock edge that ends the strobe. The pixel inputs are sampled on no other cycle. Each colour is split into a 6-bit low part and a 2-bit high part, and the high parts share a fourth lane.

Top module: `px7_lvds_serializer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `data_o` and `clk_o` are 0 and `strobe_o` is 1. A reset in the middle of a word abandons that word and restarts the phase.
- R2: `strobe_o` is high for exactly one cycle in every seven.
- R3: `clk_o` sends the word 1,1,0,0,0,1,1 in every pixel period, aligned with the data slots.
- R4: Lane 0 (`data_o[0]`) sends, in slot order, green[0], then red[5], red[4], red[3], red[2], red[1], red[0].
- R5: Lane 1 sends blue[1], blue[0], then green[5], green[4], green[3], green[2], green[1].
- R6: Lane 2 sends data-enable, vertical sync, horizontal sync, then blue[5], blue[4], blue[3], blue[2].
- R7: Lane 3 sends a reserved 0, then blue[7], blue[6], green[7], green[6], red[7], red[6].
- R8: Only the pixel present on the clock edge that ends a strobe cycle is serialized. Input changes in the other six cycles do not affect any lane.
- R9: Slot s (s = 0 to 6) of a pixel captured at a load edge is on the outputs during the (s+1)-th cycle after that edge. Slot 6 therefore coincides with the next strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| red_i | input | 8 | Red component |
| grn_i | input | 8 | Green component |
| blu_i | input | 8 | Blue component |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| strobe_o | output | 1 | High in the load cycle; the pixel is sampled at its closing edge |
| data_o | output | 4 | Serial data lanes 0 to 3 |
| clk_o | output | 1 | Serial clock-pattern lane |

## Verification
A phase counter that skips or repeats a state shows within one pixel period. The clock lane stops repeating 1100011, and the strobe stops landing on every seventh cycle. A wrong bit position in the packing swaps or drops colour bits in the very next word after the pixel is loaded. The bench deserializes each lane and compares against the fields it sent, so every bit slot is checked. A load that fires outside phase 0 lets mid-word input changes reach the wire in the same word. The bench scrambles the inputs in those cycles to expose this.

// File: rtl/px7_pkg.sv
package px7_pkg;
    localparam int COLOR_W    = 8;
    localparam int SLOT_N     = 7;
    localparam int DATA_LANES = 4;
    localparam int PHASE_W    = $clog2(SLOT_N);
    localparam logic [SLOT_N-1:0] CLK_WORD = 7'b1100011;
    localparam logic RSVD_BIT = 1'b0;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] grn;
        logic [COLOR_W-1:0] blu;
        logic               hs;
        logic               vs;
        logic               de;
    } pixel_t;

    typedef logic [SLOT_N-1:0] lane_word_t;
endpackage

// File: rtl/px7_phase_gen.sv
module px7_phase_gen #(
    parameter int SLOTS = 7,
    localparam int PW = $clog2(SLOTS)
) (
    input  logic clk,
    input  logic rst,
    output logic load_o
);
    typedef struct packed {
        logic [PW-1:0] phase;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == PW'(SLOTS - 1))
            st_d.phase = '0;
        else
            st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign load_o = (st_q.phase == '0);

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.phase < PW'(SLOTS));
    // R2
    load_single_chk: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !load_o);
endmodule

// File: rtl/px7_lane_pack.sv
module px7_lane_pack
    import px7_pkg::*;
(
    input  pixel_t                             pix_i,
    output logic [DATA_LANES-1:0][SLOT_N-1:0]  lanes_o
);
    // Bit SLOT_N-1 of each word is the first slot on the wire.
    always_comb begin
        lanes_o[0] = {pix_i.grn[0], pix_i.red[5:0]};
        lanes_o[1] = {pix_i.blu[1:0], pix_i.grn[5:1]};
        lanes_o[2] = {pix_i.de, pix_i.vs, pix_i.hs, pix_i.blu[5:2]};
        lanes_o[3] = {RSVD_BIT, pix_i.blu[7:6], pix_i.grn[7:6], pix_i.red[7:6]};
    end
endmodule

// File: rtl/px7_shift_lane.sv
module px7_shift_lane #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] par_i,
    output logic         ser_o
);
    typedef struct packed {
        logic [W-1:0] sreg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) st_d.sreg = par_i;
        else        st_d.sreg = {st_q.sreg[W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ser_o = st_q.sreg[W-1];

    // R9
    first_slot_chk: assert property (@(posedge clk) disable iff (rst)
        $past(load_i && !rst) |-> ser_o == $past(par_i[W-1]));
endmodule

// File: rtl/px7_lvds_serializer.sv
module px7_lvds_serializer
    import px7_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [COLOR_W-1:0]    red_i,
    input  logic [COLOR_W-1:0]    grn_i,
    input  logic [COLOR_W-1:0]    blu_i,
    input  logic                  hsync_i,
    input  logic                  vsync_i,
    input  logic                  de_i,
    output logic                  strobe_o,
    output logic [DATA_LANES-1:0] data_o,
    output logic                  clk_o
);
    logic                             load;
    pixel_t                           pix;
    logic [DATA_LANES-1:0][SLOT_N-1:0] words;

    assign pix = '{red: red_i, grn: grn_i, blu: blu_i,
                   hs: hsync_i, vs: vsync_i, de: de_i};

    px7_phase_gen #(.SLOTS(SLOT_N)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .load_o (load)
    );

    px7_lane_pack u_pack (
        .pix_i   (pix),
        .lanes_o (words)
    );

    for (genvar l = 0; l < DATA_LANES; l++) begin : g_lane
        px7_shift_lane #(.W(SLOT_N)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .load_i (load),
            .par_i  (words[l]),
            .ser_o  (data_o[l])
        );
    end

    px7_shift_lane #(.W(SLOT_N)) u_clk_lane (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .par_i  (CLK_WORD),
        .ser_o  (clk_o)
    );

    assign strobe_o = load;

    // R1
    reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (strobe_o && data_o == '0 && !clk_o));
    // R3
    clk_first_slot_chk: assert property (@(posedge clk) disable iff (rst)
        $past(strobe_o && !rst) |-> clk_o);
    // R3
    clk_last_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && $past(!rst)) |-> clk_o);
endmodule

// File: tb/tb_px7_lvds_serializer.sv
module tb_px7_lvds_serializer;
    import px7_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] red_i = '0, grn_i = '0, blu_i = '0;
    logic hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
    logic strobe_o, clk_o;
    logic [3:0] data_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    px7_lvds_serializer dut (
        .clk(clk), .rst(rst), .red_i(red_i), .grn_i(grn_i), .blu_i(blu_i),
        .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i),
        .strobe_o(strobe_o), .data_o(data_o), .clk_o(clk_o)
    );

    // Fields: [26:19] red, [18:11] green, [10:3] blue, [2] hs, [1] vs, [0] de
    localparam logic [26:0] VEC [8] = '{
        27'h0,
        27'h7FF_FFFF,
        {8'hFF, 8'h00, 8'h00, 3'b001},
        {8'h00, 8'hFF, 8'h00, 3'b010},
        {8'h00, 8'h00, 8'hFF, 3'b100},
        {8'hAA, 8'h55, 8'hC3, 3'b101},
        {8'h01, 8'h80, 8'h3C, 3'b011},
        {8'hC0, 8'h41, 8'h02, 3'b110}
    };

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input pixel_t p);
        red_i = p.red; grn_i = p.grn; blu_i = p.blu;
        hsync_i = p.hs; vsync_i = p.vs; de_i = p.de;
    endtask

    // Call at a falling edge where strobe_o is high.
    task automatic send(input pixel_t p, input bit scramble);
        logic [6:0] w [4];
        logic [6:0] cw;
        string pre;
        pre = scramble ? "R8" : "R9";
        chk(strobe_o == 1'b1, "R2 strobe at load", 32'(strobe_o), 32'd1);
        drive(p);
        cw = '0;
        for (int l = 0; l < 4; l++) w[l] = '0;
        for (int s = 0; s < 7; s++) begin
            @(negedge clk);
            for (int l = 0; l < 4; l++) w[l] = {w[l][5:0], data_o[l]};
            cw = {cw[5:0], clk_o};
            if (strobe_o != (s == 6))
                chk(1'b0, "R2 strobe period", 32'(strobe_o), 32'(s == 6));
            if (scramble && s < 6) drive(pixel_t'(27'($urandom())));
        end
        chk(cw == 7'b1100011, "R3 clock word", 32'(cw), 32'h63);
        chk(w[0] == {p.grn[0], p.red[5:0]}, {pre, " R4 lane0"},
            32'(w[0]), 32'({p.grn[0], p.red[5:0]}));
        chk(w[1] == {p.blu[1:0], p.grn[5:1]}, {pre, " R5 lane1"},
            32'(w[1]), 32'({p.blu[1:0], p.grn[5:1]}));
        chk(w[2] == {p.de, p.vs, p.hs, p.blu[5:2]}, {pre, " R6 lane2"},
            32'(w[2]), 32'({p.de, p.vs, p.hs, p.blu[5:2]}));
        chk(w[3] == {1'b0, p.blu[7:6], p.grn[7:6], p.red[7:6]}, {pre, " R7 lane3"},
            32'(w[3]), 32'({1'b0, p.blu[7:6], p.grn[7:6], p.red[7:6]}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog expired actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        drive(pixel_t'(27'h5A5_A5A5));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(data_o == 4'b0, "R1 data in reset", 32'(data_o), 32'd0);
        chk(clk_o == 1'b0, "R1 clock lane in reset", 32'(clk_o), 32'd0);
        chk(strobe_o == 1'b1, "R1 phase in reset", 32'(strobe_o), 32'd1);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < 8; i++) send(pixel_t'(VEC[i]), 1'b0);

        // Random pixels
        for (int i = 0; i < 30; i++) send(pixel_t'(27'($urandom())), 1'b0);

        // R8: inputs changed in non-load cycles
        for (int i = 0; i < 10; i++) send(pixel_t'(27'($urandom())), 1'b1);

        // R1: reset in the middle of a word
        drive(pixel_t'(27'h7FF_FFFF));
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(data_o == 4'b0, "R1 mid-word reset data", 32'(data_o), 32'd0);
        chk(clk_o == 1'b0, "R1 mid-word reset clock", 32'(clk_o), 32'd0);
        chk(strobe_o == 1'b1, "R1 mid-word reset phase", 32'(strobe_o), 32'd1);
        rst = 1'b0;
        send(pixel_t'(VEC[5]), 1'b0);
        send(pixel_t'(VEC[6]), 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule